// File: doc/BRIEF.md
# Two-Bit Digit Partial Product Generator

This block multiplies a signed coefficient by a signed two's-complement sample without any adder per digit. The sample is cut into two-bit digits. Each digit is decoded into one-hot select lines, and these lines gate a small set of multiples of the coefficient through AND/OR selection cells. The multiples are computed once and shared by every digit: the coefficient, its double, its triple, and the negations of the coefficient and its double. The result is one partial product per digit, each two bits wider than the coefficient.

The top digit carries the sample's sign. Its cell is fed the coefficient, minus twice the coefficient and minus the coefficient, so the signed sample needs no correction term. A shift-add stage weights partial product j by 4^j and sums them into the full product. Both the partial products and the product are registered once. They are intended for an inner-product datapath that adds partial products of equal place value across many taps.

Top module: `pdig_mult_top`

## Requirements
- R1: The sample width SAMP_W is even and is split into SAMP_W/2 digits. Digit j is sample bits [2j+1:2j].
- R2: For every digit except the top one, the partial product equals the digit value (0, 1, 2 or 3) times the coefficient. The decoder raises at most one select line, and raises none for digit value 0.
- R3: The multiples are two's complement and sign-extended to COEF_W+2 bits. The triple of the most negative coefficient must be represented exactly (for COEF_W=8: -384).
- R4: For the top digit, the values 0, 1, 2 and 3 give the partial products 0, +coef, -2*coef and -coef.
- R5: A digit of value 0 gives an all-zero partial product, whatever the coefficient.
- R6: The product output equals the signed product coef*sample. It is COEF_W+SAMP_W bits wide and is formed as the sum of each sign-extended partial product j shifted left by 2j.
- R7: Inputs are captured on a rising clock edge at which in_valid_i is high. The captured results appear on the outputs after that edge. out_valid_o is high for exactly the cycles that follow a capture. When in_valid_i is low, pp_o and prod_o hold their values.
- R8: While rst_ni is low, out_valid_o, pp_o and prod_o are zero.
- R9: Partial product j occupies pp_o bits [j*(COEF_W+2) +: COEF_W+2].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| in_valid_i | input | 1 | Capture enable for the operands |
| coef_i | input | COEF_W | Signed coefficient |
| samp_i | input | SAMP_W | Signed sample, split into two-bit digits |
| out_valid_o | output | 1 | High in the cycle after a capture |
| pp_o | output | (SAMP_W/2)*(COEF_W+2) | Packed partial products, digit 0 in the low bits |
| prod_o | output | COEF_W+SAMP_W | Full signed product |

## Verification
The bench sweeps the top digit through all four codes with the lower digits held at zero. A design that gates positive multiples into the top cell would report +2*coef and +3*coef where -2*coef and -coef belong. The bench also drives the most negative coefficient with lower digits of value 3, where a triple held in only COEF_W+1 bits wraps, and the most negative sample with the most negative coefficient, where the product reaches its largest positive value. A sample of zero and a coefficient of zero must leave every partial product at zero. Changing the operands while in_valid_i is low must leave every output unchanged, which catches an enable that was wired wrong.

// File: rtl/pdig_pkg.sv
package pdig_pkg;

  // Value of one two-bit digit of the sample
  typedef enum logic [1:0] {
    DIG_ZERO  = 2'd0,
    DIG_ONE   = 2'd1,
    DIG_TWO   = 2'd2,
    DIG_THREE = 2'd3
  } digit_e;

  // One-hot select lines produced by the digit decoder
  typedef struct packed {
    logic pick3;
    logic pick2;
    logic pick1;
  } dsel_t;

endpackage

// File: rtl/pdig_multiples.sv
// Shared multiples of the coefficient, sign-extended to COEF_W+2 bits.
module pdig_multiples #(
  parameter int COEF_W = 8
) (
  input  logic [COEF_W-1:0] coef_i,
  output logic [COEF_W+1:0] m1_o,
  output logic [COEF_W+1:0] m2_o,
  output logic [COEF_W+1:0] m3_o,
  output logic [COEF_W+1:0] mn1_o,
  output logic [COEF_W+1:0] mn2_o
);
  localparam int PW = COEF_W + 2;

  function automatic logic [PW-1:0] widen(input logic [COEF_W-1:0] c);
    return PW'($signed(c));
  endfunction

  function automatic logic [PW-1:0] negate(input logic [PW-1:0] v);
    return (~v) + PW'(1);
  endfunction

  always_comb begin
    m1_o  = widen(coef_i);
    m2_o  = m1_o << 1;
    m3_o  = m1_o + m2_o;        // the single adder of the block
    mn1_o = negate(m1_o);
    mn2_o = negate(m2_o);
  end

  // R4: the negated multiples cancel the positive ones
  always_comb begin
    assert_negate_pair_R4: assert ((mn1_o + m1_o) == '0 && (mn2_o + m2_o) == '0)
      else $error("negated multiple mismatch");
  end

endmodule

// File: rtl/pdig_decode.sv
// Two-bit digit to one-hot select lines.
module pdig_decode (
  input  logic [1:0]            digit_i,
  output pdig_pkg::dsel_t       sel_o
);
  import pdig_pkg::*;

  always_comb begin
    sel_o = '0;
    case (digit_e'(digit_i))
      DIG_ONE:   sel_o.pick1 = 1'b1;
      DIG_TWO:   sel_o.pick2 = 1'b1;
      DIG_THREE: sel_o.pick3 = 1'b1;
      default:   sel_o = '0;
    endcase
  end

  // R2: never more than one select line, none for digit zero
  always_comb begin
    assert_dec_onehot_R2: assert ($onehot0(sel_o) && ((digit_i == 2'd0) == (sel_o == '0)))
      else $error("decoder select lines malformed");
  end

endmodule

// File: rtl/pdig_select_cell.sv
// AND/OR selection of one of three multiples under a one-hot select.
module pdig_select_cell #(
  parameter int PW = 10
) (
  input  pdig_pkg::dsel_t  sel_i,
  input  logic [PW-1:0]    opt1_i,
  input  logic [PW-1:0]    opt2_i,
  input  logic [PW-1:0]    opt3_i,
  output logic [PW-1:0]    pp_o
);
  logic [PW-1:0] gated1, gated2, gated3;

  always_comb begin
    gated1 = opt1_i & {PW{sel_i.pick1}};
    gated2 = opt2_i & {PW{sel_i.pick2}};
    gated3 = opt3_i & {PW{sel_i.pick3}};
    pp_o   = (gated1 | gated2) | gated3;
  end

  // R5: an idle digit contributes nothing
  always_comb begin
    if (sel_i == '0) begin
      assert_zero_digit_R5: assert (pp_o == '0)
        else $error("idle digit produced a nonzero partial product");
    end
  end

endmodule

// File: rtl/pdig_shift_add.sv
// Weights partial product j by 4^j and sums all of them.
module pdig_shift_add #(
  parameter int COEF_W = 8,
  parameter int SAMP_W = 8
) (
  input  logic [(SAMP_W/2)*(COEF_W+2)-1:0] pp_i,
  output logic [COEF_W+SAMP_W-1:0]         prod_o
);
  localparam int NDIG   = SAMP_W / 2;
  localparam int PW     = COEF_W + 2;
  localparam int PROD_W = COEF_W + SAMP_W;

  function automatic logic [PROD_W-1:0] place(input logic [PW-1:0] p, input int j);
    logic signed [PROD_W-1:0] ext;
    ext = PROD_W'($signed(p));
    return ext << (2 * j);
  endfunction

  always_comb begin
    prod_o = '0;
    for (int j = 0; j < NDIG; j++) begin
      prod_o = prod_o + place(pp_i[j*PW +: PW], j);
    end
  end

endmodule

// File: rtl/pdig_mult_top.sv
module pdig_mult_top #(
  parameter int COEF_W = 8,
  parameter int SAMP_W = 8
) (
  input  logic                               clk_i,
  input  logic                               rst_ni,
  input  logic                               in_valid_i,
  input  logic [COEF_W-1:0]                  coef_i,
  input  logic [SAMP_W-1:0]                  samp_i,
  output logic                               out_valid_o,
  output logic [(SAMP_W/2)*(COEF_W+2)-1:0]   pp_o,
  output logic [COEF_W+SAMP_W-1:0]           prod_o
);
  localparam int NDIG   = SAMP_W / 2;
  localparam int PW     = COEF_W + 2;
  localparam int PROD_W = COEF_W + SAMP_W;

  // shared multiples
  logic [PW-1:0] m1, m2, m3, mn1, mn2;

  pdig_multiples #(.COEF_W(COEF_W)) u_multiples (
    .coef_i (coef_i),
    .m1_o   (m1),
    .m2_o   (m2),
    .m3_o   (m3),
    .mn1_o  (mn1),
    .mn2_o  (mn2)
  );

  logic [NDIG*PW-1:0] pp_comb;
  logic [PROD_W-1:0]  prod_comb;

  for (genvar j = 0; j < NDIG; j++) begin : g_digit
    pdig_pkg::dsel_t sel;

    pdig_decode u_decode (
      .digit_i (samp_i[2*j +: 2]),
      .sel_o   (sel)
    );

    if (j == NDIG - 1) begin : g_sign_digit
      // digit codes 1,2,3 stand for +1,-2,-1
      pdig_select_cell #(.PW(PW)) u_cell (
        .sel_i  (sel),
        .opt1_i (m1),
        .opt2_i (mn2),
        .opt3_i (mn1),
        .pp_o   (pp_comb[j*PW +: PW])
      );
    end else begin : g_plain_digit
      pdig_select_cell #(.PW(PW)) u_cell (
        .sel_i  (sel),
        .opt1_i (m1),
        .opt2_i (m2),
        .opt3_i (m3),
        .pp_o   (pp_comb[j*PW +: PW])
      );
    end
  end

  pdig_shift_add #(.COEF_W(COEF_W), .SAMP_W(SAMP_W)) u_shift_add (
    .pp_i   (pp_comb),
    .prod_o (prod_comb)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      out_valid_o <= 1'b0;
      pp_o        <= '0;
      prod_o      <= '0;
    end else begin
      out_valid_o <= in_valid_i;
      if (in_valid_i) begin
        pp_o   <= pp_comb;
        prod_o <= prod_comb;
      end
    end
  end

  // ---------------- named wires for the checks ----------------
  logic signed [PROD_W-1:0] coef_ext, samp_ext;
  logic [PROD_W-1:0]        chk_prod;
  logic [PW-1:0]            coef_pw;
  logic [PW-1:0]            pp_top_q;
  logic [1:0]               top_digit;

  assign coef_ext  = PROD_W'($signed(coef_i));
  assign samp_ext  = PROD_W'($signed(samp_i));
  assign chk_prod  = coef_ext * samp_ext;
  assign coef_pw   = PW'($signed(coef_i));
  assign pp_top_q  = pp_o[(NDIG-1)*PW +: PW];
  assign top_digit = samp_i[SAMP_W-1 -: 2];

  assert_prod_match_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o |-> (prod_o == $past(chk_prod)))
    else $error("product differs from signed multiply");

  assert_top_neg2_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (out_valid_o && ($past(top_digit) == 2'b10)) |-> ((pp_top_q + ($past(coef_pw) << 1)) == '0))
    else $error("top digit code 2 did not give -2*coef");

  assert_valid_follow_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(in_valid_i) |-> out_valid_o)
    else $error("out_valid_o missing after capture");

  assert_hold_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$past(in_valid_i) |-> (!out_valid_o && $stable(pp_o) && $stable(prod_o)))
    else $error("outputs moved without a capture");

endmodule

// File: tb/pdig_mult_top_tb.sv
`timescale 1ns/1ps
module pdig_mult_top_tb_top;
  localparam int W      = 8;
  localparam int L      = 8;
  localparam int NDIG   = L / 2;
  localparam int PW     = W + 2;
  localparam int PROD_W = W + L;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0;
  logic [W-1:0] coef = '0;
  logic [L-1:0] samp = '0;
  logic out_valid;
  logic [NDIG*PW-1:0] pp;
  logic [PROD_W-1:0] prod;

  int checks = 0;
  int failures = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  pdig_mult_top #(.COEF_W(W), .SAMP_W(L)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .in_valid_i(in_valid),
    .coef_i(coef), .samp_i(samp),
    .out_valid_o(out_valid), .pp_o(pp), .prod_o(prod)
  );

  task automatic check(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // expected partial product of digit j, from R2 and R4
  function automatic longint exp_pp(input longint c, input longint s, input int j);
    longint d;
    d = (s >>> (2*j)) & 3;
    if (j == NDIG-1 && d >= 2) d = d - 4;
    return c * d;
  endfunction

  // drive one capture, then sample after the capturing edge (R7)
  task automatic apply(input logic [W-1:0] c, input logic [L-1:0] s);
    @(negedge clk);
    coef = c; samp = s; in_valid = 1'b1;
    @(posedge clk);
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic check_all(input string tag);
    longint c, s, a, e;
    c = longint'($signed(coef));
    s = longint'($signed(samp));
    check(out_valid == 1'b1, {tag, " R7 valid"}, out_valid, 1);
    for (int j = 0; j < NDIG; j++) begin
      a = longint'($signed(pp[j*PW +: PW]));   // R9 slice position
      e = exp_pp(c, s, j);
      check(a == e, (j == NDIG-1) ? {tag, " R4 top pp"} : {tag, " R1 R2 pp"}, a, e);
    end
    a = longint'($signed(prod));
    e = c * s;
    check(a == e, {tag, " R6 product"}, a, e);
  endtask

  task automatic t_reset();
    @(negedge clk);
    check(out_valid == 1'b0, "R8 valid in reset", out_valid, 0);
    check(pp == '0, "R8 pp in reset", longint'(pp), 0);
    check(prod == '0, "R8 prod in reset", longint'(prod), 0);
    rst_n = 1'b1;
  endtask

  task automatic t_lower_digits();
    apply(8'd37, 8'b00_11_10_01);  check_all("lower digits 3,2,1");
    apply(8'hE3, 8'b00_01_00_11);  check_all("lower digits neg coef");
    apply(8'd5,  8'b00_10_11_00);  check_all("lower digits mixed");
  endtask

  task automatic t_top_digit();
    for (int d = 0; d < 4; d++) begin
      apply(8'hFB, 8'(d << 6));
      check_all("R4 top digit sweep");
    end
    apply(8'd100, 8'h80); check_all("R4 top code 2 pos coef");
  endtask

  task automatic t_corners();
    apply(8'h80, 8'h3F); check_all("R3 triple of most negative");
    check($signed(pp[0 +: PW]) == -384, "R3 3w exact", longint'($signed(pp[0 +: PW])), -384);
    apply(8'h80, 8'h80); check_all("R6 most negative both");
    apply(8'h7F, 8'h80); check_all("R6 max coef min sample");
    apply(8'h80, 8'hFF); check_all("R6 min coef sample -1");
    apply(8'h5A, 8'h00); check_all("R5 zero sample");
    check(pp == '0, "R5 all pp zero", longint'(pp), 0);
    apply(8'h00, 8'hD7); check_all("R5 zero coef");
    check(pp == '0, "R5 zero coef pp", longint'(pp), 0);
  endtask

  task automatic t_random();
    for (int i = 0; i < 40; i++) begin
      apply(W'($urandom), L'($urandom));
      check_all("R6 random");
    end
  endtask

  task automatic t_hold();
    logic [NDIG*PW-1:0] pp_keep;
    logic [PROD_W-1:0] prod_keep;
    apply(8'd77, 8'hB6); check_all("R7 before hold");
    pp_keep = pp; prod_keep = prod;
    coef = 8'h11; samp = 8'h22;          // in_valid stays low
    repeat (3) @(negedge clk);
    check(out_valid == 1'b0, "R7 valid drops", out_valid, 0);
    check(pp == pp_keep, "R7 pp held", longint'(pp), longint'(pp_keep));
    check(prod == prod_keep, "R7 prod held", longint'(prod), longint'(prod_keep));
  endtask

  initial begin
    repeat (3) @(posedge clk);
    t_reset();
    t_lower_digits();
    t_top_digit();
    t_corners();
    t_random();
    t_hold();
    if (!finished) begin
      finished = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    #100000;
    if (!finished) begin
      finished = 1'b1;
      checks++;
      failures++;
      $display("FAIL watchdog R7 actual=%0d expected=%0d", 0, 1);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule